// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block controls one bank of thirty general-purpose pins behind a small 32-bit register bus. Each pin can be driven from a stored output value or observed as an input, and each pin can flag an interrupt on a chosen level or on a chosen edge. All the pins of the bank share one interrupt line.

Software gives a pin to the GPIO logic by setting its function-enable bit. While that bit is clear, the pad is left to other logic: the output enable stays low, the input reads as zero, and no interrupt condition is recorded. Pad inputs are brought into the clock domain through two flops. Edges are found by comparing the synchronized value with its value one clock earlier. Pending flags are cleared by writing a zero into their bit position. There is no mode that fires on both edges. Software gets the same effect by setting the polarity to the inverse of the current input level after each event.

Register offsets: direction 0x00, polarity 0x20, trigger type 0x30, interrupt enable 0x40, pending status 0x50, function enable 0x60, input level 0x70, output value 0x80. Pin n uses bit n of each register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset the direction register reads 0x3FFFFFFF (all pins inputs). Every other register reads zero, and pad_oe and irq are low.
- R2: A read strobe captures the addressed register into bus_rdata at the next clock edge. The writable registers (direction, polarity, type, enable, function enable, output value) read back what was written. Bits 31:30 always read zero, and an address outside the register map reads zero.
- R3: pad_oe bit n is high exactly when function-enable bit n is 1 and direction bit n is 0 (output). pad_out bit n equals output-value bit n while driven and is 0 otherwise.
- R4: The input-level register returns the synchronized pad level for pins whose function-enable bit is 1, and 0 for the other pins. Writes to it have no effect.
- R5: With type bit 0 (level), a status bit is set on every cycle where the synchronized input equals the polarity bit (1 = high, 0 = low).
- R6: With type bit 1 (edge), a status bit is set when the synchronized input differs from its value one clock earlier in the direction named by polarity (1 = rising, 0 = falling).
- R7: Writing the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. A trigger present in the same cycle keeps its bit set.
- R8: While a pin's function-enable bit is 0, its status bit is never set.
- R9: Status bits are set whatever the interrupt enable. irq is high exactly when some pin has both its status bit and its enable bit set.
- R10: Rewriting the polarity of an edge pin to the inverse of its current input lets the next opposite edge set the status bit again, which gives a both-edge behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the edge after the read strobe |
| pad_in | input | 30 | Pad input levels (asynchronous) |
| pad_out | output | 30 | Pad output values |
| pad_oe | output | 30 | Pad output enables |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach is a status bit for a pin whose trigger condition stays true while software tries to clear it. A level pin re-sets its bit in the same cycle as the clearing write, so the bench must hold the pad level across the write and then read the bit back. Random phases also risk setting bits by accident while the configuration is half rewritten. The stimulus therefore drops every function-enable bit before it rewrites polarity and type, and restores them last, so the bench model only has to account for the final configuration and for pad changes made while that configuration is stable.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_PINS   = 30;
    localparam int BANK_DATA_W = 32;
    localparam int BANK_ADDR_W = 8;

    // Byte offsets decoded by software drivers
    localparam logic [15:0] OFS_DIR  = 16'h0000;
    localparam logic [15:0] OFS_POL  = 16'h0020;
    localparam logic [15:0] OFS_TYP  = 16'h0030;
    localparam logic [15:0] OFS_IEN  = 16'h0040;
    localparam logic [15:0] OFS_STS  = 16'h0050;
    localparam logic [15:0] OFS_FEN  = 16'h0060;
    localparam logic [15:0] OFS_DIN  = 16'h0070;
    localparam logic [15:0] OFS_DOUT = 16'h0080;

    typedef enum logic [3:0] {
        RID_DIR,
        RID_POL,
        RID_TYP,
        RID_IEN,
        RID_STS,
        RID_FEN,
        RID_DIN,
        RID_DOUT,
        RID_NONE
    } reg_id_t;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_kind_t;

    function automatic reg_id_t decode_offset(input logic [15:0] ofs);
        reg_id_t id;
        case (ofs)
            OFS_DIR:  id = RID_DIR;
            OFS_POL:  id = RID_POL;
            OFS_TYP:  id = RID_TYP;
            OFS_IEN:  id = RID_IEN;
            OFS_STS:  id = RID_STS;
            OFS_FEN:  id = RID_FEN;
            OFS_DIN:  id = RID_DIN;
            OFS_DOUT: id = RID_DOUT;
            default:  id = RID_NONE;
        endcase
        return id;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W      = 30,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_trig.sv
module gpio_bank_trig #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_now,
    input  logic [W-1:0] trig_type,
    input  logic [W-1:0] trig_pol,
    input  logic [W-1:0] fn_en,
    output logic [W-1:0] hit
);
    import gpio_bank_pkg::*;

    logic [W-1:0] level_prev_q;

    always_ff @(posedge clk) begin
        if (rst) level_prev_q <= '0;
        else     level_prev_q <= level_now;
    end

    genvar p;
    generate
        for (p = 0; p < W; p++) begin : g_pin
            logic lvl_match;
            logic rise;
            logic fall;
            logic edge_match;
            always_comb begin
                lvl_match  = (level_now[p] == trig_pol[p]);
                rise       = level_now[p] & ~level_prev_q[p];
                fall       = ~level_now[p] & level_prev_q[p];
                edge_match = trig_pol[p] ? rise : fall;
                if (!fn_en[p])
                    hit[p] = 1'b0;
                else if (trig_kind_t'(trig_type[p]) == TRIG_EDGE)
                    hit[p] = edge_match;
                else
                    hit[p] = lvl_match;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
    parameter int W  = 30,
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [W-1:0]  din_view,
    input  logic [W-1:0]  hit,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  pol_q,
    output logic [W-1:0]  typ_q,
    output logic [W-1:0]  ien_q,
    output logic [W-1:0]  fen_q,
    output logic [W-1:0]  dout_q,
    output logic [W-1:0]  sts_q
);
    import gpio_bank_pkg::*;

    reg_id_t      sel;
    logic [W-1:0] wbits;
    logic [W-1:0] rd_mux;
    logic [W-1:0] sts_keep;

    assign sel   = decode_offset(16'(bus_addr));
    assign wbits = bus_wdata[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            pol_q  <= '0;
            typ_q  <= '0;
            ien_q  <= '0;
            fen_q  <= '0;
            dout_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                RID_DIR:  dir_q  <= wbits;
                RID_POL:  pol_q  <= wbits;
                RID_TYP:  typ_q  <= wbits;
                RID_IEN:  ien_q  <= wbits;
                RID_FEN:  fen_q  <= wbits;
                RID_DOUT: dout_q <= wbits;
                default: ;
            endcase
        end
    end

    // zero-written bits drop, new triggers win
    always_comb begin
        sts_keep = sts_q;
        if (bus_wr && sel == RID_STS) sts_keep = sts_q & wbits;
    end

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= sts_keep | hit;
    end

    always_comb begin
        case (sel)
            RID_DIR:  rd_mux = dir_q;
            RID_POL:  rd_mux = pol_q;
            RID_TYP:  rd_mux = typ_q;
            RID_IEN:  rd_mux = ien_q;
            RID_STS:  rd_mux = sts_q;
            RID_FEN:  rd_mux = fen_q;
            RID_DIN:  rd_mux = din_view;
            RID_DOUT: rd_mux = dout_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= DW'(rd_mux);
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int NUM_PINS   = gpio_bank_pkg::BANK_PINS,
    parameter int DATA_W     = gpio_bank_pkg::BANK_DATA_W,
    parameter int ADDR_W     = gpio_bank_pkg::BANK_ADDR_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    logic [NUM_PINS-1:0] pad_sync;
    logic [NUM_PINS-1:0] din_view;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] dir_q, pol_q, typ_q, ien_q, fen_q, dout_q, sts_q;

    gpio_bank_sync #(.W(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_bank_trig #(.W(NUM_PINS)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .level_now (pad_sync),
        .trig_type (typ_q),
        .trig_pol  (pol_q),
        .fn_en     (fen_q),
        .hit       (hit)
    );

    gpio_bank_regs #(.W(NUM_PINS), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din_view  (din_view),
        .hit       (hit),
        .dir_q     (dir_q),
        .pol_q     (pol_q),
        .typ_q     (typ_q),
        .ien_q     (ien_q),
        .fen_q     (fen_q),
        .dout_q    (dout_q),
        .sts_q     (sts_q)
    );

    assign din_view = pad_sync & fen_q;
    assign pad_oe   = fen_q & ~dir_q;
    assign pad_out  = dout_q & pad_oe;
    assign irq      = |(sts_q & ien_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int W  = 30,
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [W-1:0]  pad_oe,
    input logic          irq,
    input logic [W-1:0]  sts_q,
    input logic [W-1:0]  ien_q,
    input logic [W-1:0]  fen_q
);
    import gpio_bank_pkg::*;

    logic sts_wr;
    assign sts_wr = bus_wr && (decode_offset(16'(bus_addr)) == RID_STS);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && !irq)); // R1

    AST_RDATA_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DW-1:W] == '0); // R2

    AST_OE_OWNED: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~fen_q) == '0); // R3

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !sts_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R7

    AST_STS_ONES_KEEP: assert property (@(posedge clk) disable iff (rst)
        sts_wr |=> (($past(sts_q) & $past(bus_wdata[W-1:0]) & ~sts_q) == '0)); // R7

    AST_NO_SET_UNOWNED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((sts_q & ~$past(sts_q) & ~$past(fen_q)) == '0)); // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_q != '0 && sts_q != '0)); // R9
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(NUM_PINS), .DW(DATA_W), .AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .sts_q     (sts_q),
    .ien_q     (ien_q),
    .fen_q     (fen_q)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [29:0] M = 30'h3FFF_FFFF;
    localparam logic [7:0] A_DIR = 8'h00, A_POL = 8'h20, A_TYP = 8'h30, A_IEN = 8'h40,
                           A_STS = 8'h50, A_FEN = 8'h60, A_DIN = 8'h70, A_DOUT = 8'h80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [29:0] pad_in = '0, pad_out, pad_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [29:0] m_dir, m_pol, m_typ, m_ien, m_fen, m_dout, m_sts, m_pad;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bench model of trigger conditions, from the requirements
    function automatic logic [29:0] level_set(input logic [29:0] lv);
        return m_fen & ~m_typ & ~(lv ^ m_pol);
    endfunction

    function automatic logic [29:0] edge_set(input logic [29:0] old_lv, input logic [29:0] new_lv);
        return m_fen & m_typ & ((new_lv & ~old_lv & m_pol) | (~new_lv & old_lv & ~m_pol));
    endfunction

    function automatic logic exp_irq();
        return |(m_sts & m_ien);
    endfunction

    task automatic drive_pad(input logic [29:0] v);
        logic [29:0] old_lv;
        old_lv = m_pad;
        @(negedge clk);
        pad_in = v;
        m_pad  = v;
        idle(4);
        m_sts = m_sts | level_set(old_lv) | level_set(v) | edge_set(old_lv, v);
    endtask

    initial begin
        logic [31:0] r;
        logic [29:0] w;
        void'($urandom(32'd7153));
        m_dir = M; m_pol = '0; m_typ = '0; m_ien = '0; m_fen = '0; m_dout = '0;
        m_sts = '0; m_pad = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(A_DIR, r);  chk("R1 dir", r, {2'b0, M});
        rd(A_POL, r);  chk("R1 pol", r, 0);
        rd(A_STS, r);  chk("R1 sts", r, 0);
        rd(A_FEN, r);  chk("R1 fen", r, 0);
        chk("R1 pad_oe", {2'b0, pad_oe}, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 readback, top bits, unmapped
        wr(A_DIR, '1); wr(A_POL, '1); wr(A_TYP, '1); wr(A_IEN, '1); wr(A_DOUT, '1);
        wr(A_FEN, '1);
        rd(A_POL, r);  chk("R2 pol", r, {2'b0, M});
        rd(A_TYP, r);  chk("R2 typ", r, {2'b0, M});
        rd(A_IEN, r);  chk("R2 ien", r, {2'b0, M});
        rd(A_DOUT, r); chk("R2 dout", r, {2'b0, M});
        wr(A_STS, '1);
        rd(A_STS, r);  chk("R7 ones leave status", r, 0);
        rd(8'h10, r);  chk("R2 unmapped", r, 0);
        wr(A_FEN, 0); wr(A_POL, 0); wr(A_TYP, 0); wr(A_IEN, 0); wr(A_DOUT, 0);

        // R3 pad drive
        wr(A_DOUT, 32'h2AAA_5555); wr(A_DIR, 32'h0F0F_0F0F); wr(A_FEN, 32'h00FF_FF00);
        chk("R3 pad_oe", {2'b0, pad_oe}, {2'b0, 30'h00FF_FF00 & ~30'h0F0F_0F0F});
        chk("R3 pad_out", {2'b0, pad_out}, {2'b0, 30'h2AAA_5555 & 30'h00FF_FF00 & ~30'h0F0F_0F0F});
        m_dir = 30'h0F0F_0F0F; m_dout = 30'h2AAA_5555; m_fen = 30'h00FF_FF00;

        // R4 input view; pol 0 level pins with fen set will log status
        drive_pad(30'h1234_5678);
        rd(A_DIN, r);  chk("R4 din", r, {2'b0, 30'h1234_5678 & m_fen});
        wr(A_DIN, '1);
        rd(A_DIN, r);  chk("R4 din write ignored", r, {2'b0, 30'h1234_5678 & m_fen});
        rd(A_DOUT, r); chk("R4 dout untouched", r, {2'b0, m_dout});
        rd(A_STS, r);  chk("R5 level low", r, {2'b0, m_sts});
        wr(A_FEN, 0); m_fen = '0;
        wr(A_STS, 0); m_sts = '0;

        // random phase
        for (int step = 0; step < 48; step++) begin
            if (step % 8 == 0) begin
                wr(A_FEN, 0); m_fen = '0;
                m_pol = 30'($urandom); m_typ = 30'($urandom); m_ien = 30'($urandom);
                wr(A_POL, {2'b0, m_pol}); wr(A_TYP, {2'b0, m_typ}); wr(A_IEN, {2'b0, m_ien});
                m_fen = 30'($urandom) | 30'h1;
                wr(A_FEN, {2'b0, m_fen});
                m_sts = m_sts | level_set(m_pad);
            end
            drive_pad(30'($urandom));
            rd(A_STS, r); chk("R5 R6 status", r, {2'b0, m_sts});
            chk("R9 irq", {31'b0, irq}, {31'b0, exp_irq()});
            rd(A_DIN, r); chk("R4 din random", r, {2'b0, m_pad & m_fen});
            w = 30'($urandom);
            wr(A_STS, {2'b0, w});
            m_sts = (m_sts & w) | level_set(m_pad);
            rd(A_STS, r); chk("R7 clear", r, {2'b0, m_sts});
        end

        // R10 both-edge emulation on pin 3
        wr(A_FEN, 0); m_fen = '0;
        wr(A_STS, 0); m_sts = '0;
        drive_pad('0);
        wr(A_TYP, 32'h8); wr(A_POL, 32'h8); wr(A_IEN, 32'h8); wr(A_FEN, 32'h8);
        drive_pad(30'h8);
        rd(A_STS, r); chk("R6 rising", r, 32'h8);
        chk("R9 irq rising", {31'b0, irq}, 1);
        wr(A_STS, 0);
        rd(A_STS, r); chk("R7 edge cleared", r, 0);
        chk("R9 irq low", {31'b0, irq}, 0);
        rd(A_DIN, r);
        wr(A_POL, ~r & 32'h8);
        drive_pad('0);
        rd(A_STS, r); chk("R10 falling after rearm", r, 32'h8);
        wr(A_STS, 0);

        // R8 unowned pin, then R5/R7/R9 on a held level
        wr(A_FEN, 0); wr(A_STS, 0);
        wr(A_TYP, 0); wr(A_POL, 32'h20); wr(A_IEN, 0);
        drive_pad(30'h20);
        rd(A_STS, r); chk("R8 no status when unowned", r, 0);
        wr(A_FEN, 32'h20); idle(2);
        rd(A_STS, r); chk("R5 level high", r, 32'h20);
        chk("R9 irq masked", {31'b0, irq}, 0);
        wr(A_STS, 0);
        rd(A_STS, r); chk("R7 held level wins clear", r, 32'h20);
        wr(A_IEN, 32'h20);
        chk("R9 irq enabled", {31'b0, irq}, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule